// File: doc/BRIEF.md
# Folded-Array Unsigned Squarer

This block returns the square of an unsigned N-bit operand as a 2N-bit result. It is built for circuits that square at a high rate. It is not a general multiplier with both inputs tied together. Because the two operands are the same, each cross term appears twice in the full product matrix, so the two copies are merged into one bit one column higher. Each term on the main diagonal reduces to the operand bit itself. In the low half of the array, a half-adder identity then shortens the columns further: the diagonal bit and its neighbouring cross term are swapped for an "and-not" product in the same column and an "and" product in the next column up. A Dadda tree of carry-save adders reduces the array to two rows. The tree combines bits as late as it can while still using the fewest stages. A ripple adder whose lowest bit has weight 2^3 adds the two rows.

The width N can be set from 4 to 16. The column heights, the adder placement and the adder widths are all worked out at elaboration from N. A parameter selects whether the result is registered. When it is, the result and a valid flag are loaded on the clock edge after a valid operand is presented. A synchronous reset clears both.

Top module: `sq_squarer`

## Requirements
- R1: For every operand value A, `square` equals A*A as an unsigned 2N-bit number.
- R2: Result bit 0 equals operand bit 0, and result bit 1 is always 0.
- R3: Result bit 2 equals operand bit 1 AND NOT operand bit 0.
- R4: With `REG_OUT`=1, an edge that samples `inValid` high loads the square of `operand` into `square`. At every edge, `outValid` takes the value that `inValid` had at that edge.
- R5: With `REG_OUT`=1, an edge that samples `inValid` low leaves `square` unchanged, whatever the value on `operand`.
- R6: With `REG_OUT`=1, an edge that samples `rst` high clears `square` to 0 and `outValid` to 0.
- R7: With `REG_OUT`=0, `square` follows `operand` combinationally, and `outValid` equals `inValid`.
- R8: The extreme operands give exact results: 0 gives 0, and 2^N-1 gives 2^(2N) - 2^(N+1) + 1. A one-hot operand 2^k gives 2^(2k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `operand` as valid in this cycle |
| operand | input | N | Unsigned value to be squared |
| square | output | 2N | Unsigned square of the operand |
| outValid | output | 1 | Marks `square` as valid |

## Verification
The clocked properties assume that `operand` and `inValid` are steady at each rising edge. They also assume that `rst` is held high for at least one edge before the first valid operand. The stimulus changes inputs only on falling edges and opens with several reset cycles, so it stays within these assumptions. Because a low-valid cycle changes `operand` as well, the hold property is exercised against a moving input. The random mix turns `inValid` on and off, so both the load path and the hold path are covered.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef struct packed {
    logic clear;
    logic load;
    logic markValid;
  } sq_strobe_t;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // Majority-based full adder: carry first, sum derived from it. Returns {carry, sum}.
  function automatic logic [1:0] fullAdd(input logic x, input logic y, input logic z);
    logic cy;
    cy = maj3(x, y, z);
    return {cy, maj3(~cy, z, maj3(x, y, ~z))};
  endfunction

  // Half-adder substitution is applied at diagonal i when weight 2^(2i) lies in [2^2, 2^(n+1)].
  function automatic bit substAt(input int n, input int i);
    return (i >= 1) && (2 * i <= n + 1) && (2 * i != 2 * n - 1);
  endfunction

  // Number of bits in column c of the folded, pre-reduced array.
  function automatic int ppHeight(input int n, input int c);
    int cnt;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (!substAt(n, i) && 2 * i == c) cnt++;
      for (int j = 0; j < i; j++) begin
        if (j == i - 1 && substAt(n, i)) begin
          if (2 * i == c) cnt++;
          if (2 * i + 1 == c) cnt++;
        end else if (i + j + 1 == c) begin
          cnt++;
        end
      end
    end
    return cnt;
  endfunction

  // Dadda height targets 2, 3, 4, 6, 9, 13, ...
  function automatic int daddaTarget(input int s);
    int d;
    d = 2;
    for (int k = 0; k < s; k++) d = (d * 3) / 2;
    return d;
  endfunction

endpackage

// File: rtl/sq_ppgen.sv
module sq_ppgen #(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int MAXH = N
) (
  input  logic [N-1:0]          operand,
  output logic [W-1:0][MAXH-1:0] ppCol
);
  int fill [W];

  always_comb begin
    ppCol = '0;
    for (int c = 0; c < W; c++) fill[c] = 0;
    for (int i = 0; i < N; i++) begin
      if (!sq_pkg::substAt(N, i)) begin
        ppCol[2*i][fill[2*i]] = operand[i];
        fill[2*i] = fill[2*i] + 1;
      end
      for (int j = 0; j < i; j++) begin
        if (j == i - 1 && sq_pkg::substAt(N, i)) begin
          ppCol[2*i][fill[2*i]] = operand[i] & ~operand[j];
          fill[2*i] = fill[2*i] + 1;
          ppCol[2*i+1][fill[2*i+1]] = operand[i] & operand[j];
          fill[2*i+1] = fill[2*i+1] + 1;
        end else begin
          ppCol[i+j+1][fill[i+j+1]] = operand[i] & operand[j];
          fill[i+j+1] = fill[i+j+1] + 1;
        end
      end
    end
  end

endmodule

// File: rtl/sq_reduce.sv
module sq_reduce #(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int MAXH = N,
  localparam int NSTG = 8
) (
  input  logic [W-1:0][MAXH-1:0] ppCol,
  output logic [W-1:0]           rowA,
  output logic [W-1:0]           rowB
);
  logic [W-1:0][MAXH-1:0] cur;
  logic [W-1:0][MAXH-1:0] nxt;
  int   hgt [W];
  int   nhg [W];
  int   target;
  int   tallest;
  int   avail;
  int   pick;
  logic [1:0] fa;

  always_comb begin
    cur = ppCol;
    nxt = '0;
    fa = '0;
    target = 0;
    tallest = 0;
    avail = 0;
    pick = 0;
    for (int c = 0; c < W; c++) begin
      hgt[c] = sq_pkg::ppHeight(N, c);
      nhg[c] = 0;
    end
    for (int s = NSTG - 1; s >= 0; s--) begin
      target = sq_pkg::daddaTarget(s);
      tallest = 0;
      for (int c = 0; c < W; c++) if (hgt[c] > tallest) tallest = hgt[c];
      if (target < tallest) begin
        nxt = '0;
        for (int c = 0; c < W; c++) nhg[c] = 0;
        for (int c = 0; c < W; c++) begin
          avail = hgt[c] + nhg[c];
          pick = 0;
          for (int k = 0; k < MAXH; k++) begin
            if (avail > target && pick + 1 < hgt[c]) begin
              if (avail == target + 1 || pick + 2 >= hgt[c]) begin
                fa = {cur[c][pick] & cur[c][pick+1], cur[c][pick] ^ cur[c][pick+1]};
                pick = pick + 2;
                avail = avail - 1;
              end else begin
                fa = sq_pkg::fullAdd(cur[c][pick], cur[c][pick+1], cur[c][pick+2]);
                pick = pick + 3;
                avail = avail - 2;
              end
              nxt[c][nhg[c]] = fa[0];
              nhg[c] = nhg[c] + 1;
              if (c + 1 < W) begin
                nxt[c+1][nhg[c+1]] = fa[1];
                nhg[c+1] = nhg[c+1] + 1;
              end
            end
          end
          for (int k = 0; k < MAXH; k++) begin
            if (k >= pick && k < hgt[c]) begin
              nxt[c][nhg[c]] = cur[c][k];
              nhg[c] = nhg[c] + 1;
            end
          end
        end
        cur = nxt;
        for (int c = 0; c < W; c++) hgt[c] = nhg[c];
      end
    end
    for (int c = 0; c < W; c++) begin
      rowA[c] = (hgt[c] > 0) ? cur[c][0] : 1'b0;
      rowB[c] = (hgt[c] > 1) ? cur[c][1] : 1'b0;
    end
  end

endmodule

// File: rtl/sq_ripple.sv
module sq_ripple #(
  parameter int WIDTH = 13
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  output logic [WIDTH-1:0] total
);
  logic [WIDTH-1:0] carryIn;
  assign carryIn[0] = 1'b0;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    logic [1:0] cellOut;
    assign cellOut  = sq_pkg::fullAdd(addA[k], addB[k], carryIn[k]);
    assign total[k] = cellOut[0];
    if (k + 1 < WIDTH) begin : g_chain
      assign carryIn[k+1] = cellOut[1];
    end else begin : g_top
      logic unusedCarry;
      assign unusedCarry = cellOut[1];
    end
  end

endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl (
  input  logic               rst,
  input  logic               inValid,
  output sq_pkg::sq_strobe_t stb
);
  always_comb begin
    stb.clear     = rst;
    stb.load      = inValid & ~rst;
    stb.markValid = inValid;
  end
endmodule

// File: rtl/sq_datapath.sv
module sq_datapath #(
  parameter int N = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int W = 2 * N,
  localparam int MAXH = N,
  localparam int RW = W - 3
) (
  input  logic               clk,
  input  sq_pkg::sq_strobe_t stb,
  input  logic [N-1:0]       operand,
  output logic [W-1:0]       square,
  output logic               outValid
);
  logic [W-1:0][MAXH-1:0] ppCol;
  logic [W-1:0] rowA;
  logic [W-1:0] rowB;
  logic [RW-1:0] upper;
  logic [W-1:0] sqComb;

  sq_ppgen #(.N(N)) i_ppgen (.operand(operand), .ppCol(ppCol));
  sq_reduce #(.N(N)) i_reduce (.ppCol(ppCol), .rowA(rowA), .rowB(rowB));
  sq_ripple #(.WIDTH(RW)) i_ripple (.addA(rowA[W-1:3]), .addB(rowB[W-1:3]), .total(upper));

  assign sqComb = {upper, rowA[2:0] | rowB[2:0]};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (stb.clear) begin
        square   <= '0;
        outValid <= 1'b0;
      end else begin
        outValid <= stb.markValid;
        if (stb.load) square <= sqComb;
      end
    end

    // R6
    reset_clear_chk: assert property (@(posedge clk)
      stb.clear |=> (square == '0 && !outValid));
    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (stb.clear)
      !stb.clear |=> outValid == $past(stb.markValid));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (stb.clear)
      (!stb.clear && !stb.markValid) |=> $stable(square));
    // R2
    low_bits_chk: assert property (@(posedge clk) disable iff (stb.clear)
      stb.load |=> square[1:0] == {1'b0, $past(operand[0])});
    // R3
    bit_two_chk: assert property (@(posedge clk) disable iff (stb.clear)
      stb.load |=> square[2] == $past(operand[1] & ~operand[0]));
  end else begin : g_comb
    assign square   = sqComb;
    assign outValid = stb.markValid;
  end

endmodule

// File: rtl/sq_squarer.sv
module sq_squarer #(
  parameter int N = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [N-1:0]   operand,
  output logic [2*N-1:0] square,
  output logic           outValid
);
  sq_pkg::sq_strobe_t stb;

  sq_ctrl i_ctrl (.rst(rst), .inValid(inValid), .stb(stb));

  sq_datapath #(.N(N), .REG_OUT(REG_OUT)) i_datapath (
    .clk(clk), .stb(stb), .operand(operand), .square(square), .outValid(outValid)
  );
endmodule

// File: tb/test_sq_squarer.sv
module test_sq_squarer;
  localparam int PERIOD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin8 = 1'b0;
  logic [7:0] op8 = '0;
  logic [15:0] sq8;
  logic vout8;
  logic vin4 = 1'b0;
  logic [3:0] op4 = '0;
  logic [7:0] sq4;
  logic vout4;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  sq_squarer #(.N(8), .REG_OUT(1'b1)) i_sq_squarer (
    .clk(clk), .rst(rst), .inValid(vin8), .operand(op8), .square(sq8), .outValid(vout8));

  sq_squarer #(.N(4), .REG_OUT(1'b0)) i_sq_squarer_n4 (
    .clk(clk), .rst(rst), .inValid(vin4), .operand(op4), .square(sq4), .outValid(vout4));

  function automatic longint sqRef(input longint v);
    return v * v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample 2 ns later.
  task automatic step8(input logic v, input logic [7:0] a);
    @(negedge clk);
    vin8 = v;
    op8 = a;
    @(posedge clk);
    #2;
  endtask

  initial begin
    longint held;
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #2;
    chk("R6 reset square", longint'(sq8), 0);
    chk("R6 reset valid", longint'(vout8), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1 exhaustive N=8, R4 load and valid
    for (int v = 0; v < 256; v++) begin
      step8(1'b1, v[7:0]);
      chk("R1 square n8", longint'(sq8), sqRef(v));
      chk("R4 valid", longint'(vout8), 1);
      chk("R2 low bits", longint'(sq8[1:0]), longint'({1'b0, v[0]}));
      chk("R3 bit two", longint'(sq8[2]), longint'(v[1] & ~v[0]));
    end

    // R8 extremes and one-hot operands
    step8(1'b1, 8'hFF);
    chk("R8 all ones", longint'(sq8), 65536 - 512 + 1);
    step8(1'b1, 8'h00);
    chk("R8 zero", longint'(sq8), 0);
    for (int k = 0; k < 8; k++) begin
      step8(1'b1, 8'(1 << k));
      chk("R8 one-hot", longint'(sq8), longint'(1) << (2 * k));
    end

    // R5 hold with moving operand
    step8(1'b1, 8'd201);
    step8(1'b0, 8'd17);
    chk("R5 hold square", longint'(sq8), sqRef(201));
    chk("R4 valid low", longint'(vout8), 0);
    step8(1'b0, 8'hFF);
    chk("R5 hold again", longint'(sq8), sqRef(201));

    // R4/R5 random mix
    held = sqRef(201);
    for (int n = 0; n < 3000; n++) begin
      logic v;
      logic [7:0] a;
      v = 1'($urandom % 3 != 0);
      a = 8'($urandom);
      step8(v, a);
      if (v) held = sqRef(longint'(a));
      chk("R4 R5 random square", longint'(sq8), held);
      chk("R4 random valid", longint'(vout8), longint'(v));
    end

    // R6 mid-run reset
    step8(1'b1, 8'd99);
    @(negedge clk);
    rst = 1'b1;
    vin8 = 1'b1;
    @(posedge clk);
    #2;
    chk("R6 mid reset square", longint'(sq8), 0);
    chk("R6 mid reset valid", longint'(vout8), 0);
    @(negedge clk);
    rst = 1'b0;

    // R7 combinational N=4 exhaustive
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      op4 = v[3:0];
      vin4 = v[0];
      #1;
      chk("R7 R1 square n4", longint'(sq4), sqRef(v));
      chk("R7 valid pass", longint'(vout4), longint'(v[0]));
    end
    chk("R8 all ones n4", longint'(sq4), 256 - 32 + 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule